// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches twenty-eight external interrupt pins, detects the configured trigger condition on each, and records it in a per-line pending flag. Each pin first passes through a two-stage synchronizer. Edge detection compares the current synchronized sample with the sample from the cycle before. Level detection looks only at the current sample. The pending flags that are not masked are combined into four group request lines for a downstream vectored interrupt controller. The four groups cover 4, 8, 8 and 8 lines.

Software uses a small word-wide register port. Through it, software chooses trigger modes, masks and unmasks lines, and acknowledges a line by writing a one to its pending flag. Trigger modes are packed into two configuration words, and two adjacent lines share one mode field. Reads are combinational from the addressed register. Writes take effect at the next rising clock edge.

Top module: `xirq_group_ctrl`

## Requirements
- R1: After reset, the mask register reads 0x0FFFFFFF, both configuration words and the pending register read 0, and all four group outputs are low.
- R2: A change on a pin appears in the pending register on the third rising clock edge after the change, because of two synchronizer stages and one pending register.
- R3: The 3-bit trigger code means: 000 = low level, 001 = high level, 01x = falling edge, 10x = rising edge, 11x = both edges. The default code 000 on an idle low pin therefore keeps that line pending.
- R4: The configuration word at address 0 controls lines 0 to 15, and the word at address 1 controls lines 16 to 27. The field for line n starts at bit ((n mod 16)/2)*4 and is 3 bits wide, so lines 2k and 2k+1 share one field. Bit 3 of every nibble reads 0.
- R5: Configuration bits that would belong to lines above 27 (bits 31:24 of address 1) ignore writes and read 0.
- R6: The mask register is at address 2 and holds one bit per line at bit n. A 1 masks the line. Bits 31:28 read 0.
- R7: The pending register is at address 3, bit n per line. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Bits 31:28 read 0.
- R8: A trigger detected in the same cycle as a clear of that bit leaves the bit set. An active level therefore re-sets its bit every cycle until the level is removed.
- R9: A masked line still becomes pending. The mask only hides the line from the group outputs.
- R10: Group output 0 covers lines 0–3, output 1 covers lines 4–11, output 2 covers lines 12–19 and output 3 covers lines 20–27. Each output is high in exactly those cycles where a line in its range is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_irq | input | 28 | Asynchronous external interrupt pins, one per line |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 cfg low, 1 cfg high, 2 mask, 3 pending |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| grp_irq | output | 4 | Group requests toward the vectored controller |

## Verification
The assertions rely on the register port being driven with a defined address and a defined strobe in every cycle after reset. They also assume that each pin is either stable or changes between clock edges, which is the job of the synchronizer. The stimulus drives the pins and the port only on falling clock edges, and it never leaves the strobe or the address undefined. Random pin toggles therefore reach the detectors only through the synchronizer, and every write falls into exactly one clock cycle.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int XI_LINES      = 28;
  localparam int DATA_W        = 32;
  localparam int LINES_PER_CFG = 16;
  localparam int CFG_REGS      = (XI_LINES + LINES_PER_CFG - 1) / LINES_PER_CFG;
  localparam int FIELD_W       = 3;
  localparam int FIELD_PITCH   = 4;
  localparam int N_GRP         = 4;
  localparam int ADDR_W        = 2;

  localparam int GRP_LO [N_GRP] = '{0, 4, 12, 20};
  localparam int GRP_HI [N_GRP] = '{3, 11, 19, 27};

  typedef enum logic [ADDR_W-1:0] {
    RA_CFG_LO = 2'd0,
    RA_CFG_HI = 2'd1,
    RA_MASK   = 2'd2,
    RA_PEND   = 2'd3
  } xi_addr_e;

  typedef enum logic [1:0] {
    TK_LEVEL = 2'd0,
    TK_FALL  = 2'd1,
    TK_RISE  = 2'd2,
    TK_BOTH  = 2'd3
  } xi_kind_e;

  // bit offset of a line's trigger field inside the flattened config words
  function automatic int field_off(int line);
    return (line / LINES_PER_CFG) * DATA_W
         + ((line % LINES_PER_CFG) / 2) * FIELD_PITCH;
  endfunction

  // writable bits of one config word: only fields that own an existing line
  function automatic logic [DATA_W-1:0] cfg_wmask(int word);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < XI_LINES; n++) begin
      if (n / LINES_PER_CFG == word)
        m[((n % LINES_PER_CFG) / 2) * FIELD_PITCH +: FIELD_W] = '1;
    end
    return m;
  endfunction

endpackage

// File: rtl/xirq_rst_sync.sv
module xirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] st_q;
  logic [1:0] st_d;

  always_comb st_d = {st_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign rst_q_n = st_q[1];
endmodule

// File: rtl/xirq_line_sync.sv
module xirq_line_sync #(
  parameter int N = xirq_pkg::XI_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);
  logic [N-1:0] meta_q, cur_q, prv_q;
  logic [N-1:0] meta_d, cur_d, prv_d;

  always_comb begin
    meta_d = pin;
    cur_d  = meta_q;
    prv_d  = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= meta_d;
      cur_q  <= cur_d;
      prv_q  <= prv_d;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/xirq_trig_detect.sv
module xirq_trig_detect
  import xirq_pkg::*;
#(
  parameter int N = XI_LINES
) (
  input  logic [N-1:0]                 cur,
  input  logic [N-1:0]                 prv,
  input  logic [CFG_REGS*DATA_W-1:0]   cfg_flat,
  output logic [N-1:0]                 hit
);
  logic unused_cfg;
  assign unused_cfg = ^cfg_flat;

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int OFF = field_off(i);
    logic [FIELD_W-1:0] fld;
    logic               h;

    assign fld = cfg_flat[OFF +: FIELD_W];

    always_comb begin
      unique case (xi_kind_e'(fld[2:1]))
        TK_LEVEL: h = fld[0] ? cur[i] : ~cur[i];
        TK_FALL:  h = prv[i] & ~cur[i];
        TK_RISE:  h = ~prv[i] & cur[i];
        default:  h = prv[i] ^ cur[i];
      endcase
    end

    assign hit[i] = h;
  end
endmodule

// File: rtl/xirq_regfile.sv
module xirq_regfile
  import xirq_pkg::*;
#(
  parameter int N = XI_LINES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [N-1:0]                hit,
  output logic [CFG_REGS*DATA_W-1:0]  cfg_flat,
  output logic [N-1:0]                mask_q,
  output logic [N-1:0]                pend_q,
  output logic [DATA_W-1:0]           rdata
);
  localparam int PAD = DATA_W - N;

  logic [DATA_W-1:0] cfg_q [CFG_REGS];

  for (genvar w = 0; w < CFG_REGS; w++) begin : g_cfg
    localparam logic [DATA_W-1:0] WMASK = cfg_wmask(w);
    logic              en;
    logic [DATA_W-1:0] d;

    always_comb begin
      en = wr && (addr == ADDR_W'(w));
      d  = wdata & WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q[w] <= '0;
      else if (en) cfg_q[w] <= d;
    end

    assign cfg_flat[w*DATA_W +: DATA_W] = cfg_q[w];
  end

  // mask register
  logic         mask_en;
  logic [N-1:0] mask_d;

  always_comb begin
    mask_en = wr && (xi_addr_e'(addr) == RA_MASK);
    mask_d  = wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  // pending register: new triggers win over a simultaneous clear
  logic [N-1:0] clr;
  logic [N-1:0] pend_d;

  always_comb begin
    clr    = (wr && (xi_addr_e'(addr) == RA_PEND)) ? wdata[N-1:0] : '0;
    pend_d = (pend_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // read mux
  always_comb begin
    unique case (xi_addr_e'(addr))
      RA_CFG_LO: rdata = cfg_q[0];
      RA_CFG_HI: rdata = cfg_q[1];
      RA_MASK:   rdata = {{PAD{1'b0}}, mask_q};
      default:   rdata = {{PAD{1'b0}}, pend_q};
    endcase
  end
endmodule

// File: rtl/xirq_group_merge.sv
module xirq_group_merge
  import xirq_pkg::*;
#(
  parameter int N = XI_LINES,
  parameter int G = N_GRP
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  output logic [G-1:0] grp
);
  logic [N-1:0] live;
  assign live = pend & ~mask;

  for (genvar g = 0; g < G; g++) begin : g_grp
    localparam int LO = GRP_LO[g];
    localparam int HI = GRP_HI[g];
    assign grp[g] = |live[HI:LO];
  end
endmodule

// File: rtl/xirq_group_ctrl.sv
module xirq_group_ctrl
  import xirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [XI_LINES-1:0]  ext_irq,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [N_GRP-1:0]     grp_irq
);
  logic                        rst_q_n;
  logic [XI_LINES-1:0]         smp_cur, smp_prv, hit;
  logic [XI_LINES-1:0]         mask_q, pend_q;
  logic [CFG_REGS*DATA_W-1:0]  cfg_flat;

  xirq_rst_sync i_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  xirq_line_sync #(.N(XI_LINES)) i_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .pin   (ext_irq),
    .cur   (smp_cur),
    .prv   (smp_prv)
  );

  xirq_trig_detect #(.N(XI_LINES)) i_det (
    .cur      (smp_cur),
    .prv      (smp_prv),
    .cfg_flat (cfg_flat),
    .hit      (hit)
  );

  xirq_regfile #(.N(XI_LINES)) i_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .hit      (hit),
    .cfg_flat (cfg_flat),
    .mask_q   (mask_q),
    .pend_q   (pend_q),
    .rdata    (reg_rdata)
  );

  xirq_group_merge #(.N(XI_LINES), .G(N_GRP)) i_merge (
    .pend (pend_q),
    .mask (mask_q),
    .grp  (grp_irq)
  );
endmodule

// File: rtl/xirq_checker.sv
module xirq_checker
  import xirq_pkg::*;
#(
  parameter int N = XI_LINES
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [N-1:0]      hit,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      mask_q,
  input logic [N_GRP-1:0]  grp_irq
);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && reg_addr == 2'd3) |=> ((pend_q & $past(reg_wdata[N-1:0] & ~hit)) == '0));

  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(reg_wr && reg_addr == 2'd3) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hit == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mask_q == '1) |-> (grp_irq == '0));

  a_r10_quiet_groups: assert property (@(posedge clk) disable iff (!rst_q_n)
    (grp_irq == '0) |-> ((pend_q & ~mask_q) == '0));

  a_r5_cfg_hi_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_addr == 2'd1) |-> (reg_rdata[31:24] == '0));

  a_r6_mask_top_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_addr == 2'd2) |-> (reg_rdata[DATA_W-1:N] == '0));
endmodule

bind xirq_group_ctrl xirq_checker #(.N(xirq_pkg::XI_LINES)) i_xirq_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .hit       (hit),
  .pend_q    (pend_q),
  .mask_q    (mask_q),
  .grp_irq   (grp_irq)
);

// File: tb/test_xirq_group_ctrl.sv
`timescale 1ns/1ps
module test_xirq_group_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] ext_irq;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  grp_irq;

  always #4 clk = ~clk;

  xirq_group_ctrl i_xirq_group_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grp_irq(grp_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  logic [27:0] m_s1, m_s2, m_p, m_pend, m_mask, cur_in;
  logic [31:0] m_cfg0, m_cfg1;

  function automatic logic [2:0] fld(logic [31:0] c0, logic [31:0] c1, int n);
    logic [31:0] w;
    w = (n < 16) ? c0 : c1;
    return w[((n % 16) / 2) * 4 +: 3];
  endfunction

  function automatic logic [27:0] f_hit(logic [31:0] c0, logic [31:0] c1,
                                        logic [27:0] s, logic [27:0] p);
    logic [27:0] h;
    logic [2:0]  t;
    for (int n = 0; n < 28; n++) begin
      t = fld(c0, c1, n);
      case (t[2:1])
        2'b00:   h[n] = t[0] ? s[n] : ~s[n];
        2'b01:   h[n] = p[n] & ~s[n];
        2'b10:   h[n] = ~p[n] & s[n];
        default: h[n] = p[n] ^ s[n];
      endcase
    end
    return h;
  endfunction

  function automatic logic [3:0] f_grp(logic [27:0] pend, logic [27:0] mask);
    logic [27:0] lv;
    lv = pend & ~mask;
    return {|lv[27:20], |lv[19:12], |lv[11:4], |lv[3:0]};
  endfunction

  function automatic logic [31:0] f_rd(logic [1:0] a);
    case (a)
      2'd0:    return m_cfg0;
      2'd1:    return m_cfg1;
      2'd2:    return {4'b0, m_mask};
      default: return {4'b0, m_pend};
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic wr, logic [1:0] a, logic [31:0] d);
    logic [27:0] h, clr;
    ext_irq   = cur_in;
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    h      = f_hit(m_cfg0, m_cfg1, m_s2, m_p);
    clr    = (wr && a == 2'd3) ? d[27:0] : '0;
    m_pend = (m_pend & ~clr) | h;
    m_p    = m_s2;
    m_s2   = m_s1;
    m_s1   = cur_in;
    if (wr) begin
      case (a)
        2'd0: m_cfg0 = d & 32'h7777_7777;
        2'd1: m_cfg1 = d & 32'h0077_7777;
        2'd2: m_mask = d[27:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(1'b0, 2'd3, 32'h0);
  endtask

  task automatic expect_model(string tag);
    check(grp_irq == f_grp(m_pend, m_mask), {tag, " R10 grp"}, 32'(grp_irq), 32'(f_grp(m_pend, m_mask)));
    check(reg_rdata == f_rd(reg_addr), {tag, " R7 rdata"}, reg_rdata, f_rd(reg_addr));
  endtask

  task automatic pulse_clear(int line);
    cyc(1'b1, 2'd3, 32'h1 << line);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ext_irq = '0; reg_wr = 1'b0; reg_addr = 2'd2; reg_wdata = '0;
    m_s1 = '0; m_s2 = '0; m_p = '0; m_pend = '0; m_mask = '1; cur_in = '0;
    m_cfg0 = '0; m_cfg1 = '0;

    repeat (3) @(negedge clk);
    // R1 reset values, read while reset held
    #1 check(reg_rdata == 32'h0FFF_FFFF, "R1 mask reset", reg_rdata, 32'h0FFF_FFFF);
    reg_addr = 2'd0;
    #1 check(reg_rdata == 32'h0, "R1 cfg0 reset", reg_rdata, 32'h0);
    reg_addr = 2'd3;
    #1 check(reg_rdata == 32'h0, "R1 pend reset", reg_rdata, 32'h0);
    check(grp_irq == 4'h0, "R1 grp reset", 32'(grp_irq), 32'h0);
    @(negedge clk);
    reg_addr = 2'd1;
    #1 check(reg_rdata == 32'h0, "R1 cfg1 reset", reg_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(6);

    // R3 default low-level code keeps idle-low lines pending; R1 masked groups
    check(reg_rdata == 32'h0FFF_FFFF, "R3 low level default", reg_rdata, 32'h0FFF_FFFF);
    check(grp_irq == 4'h0, "R1 all masked", 32'(grp_irq), 32'h0);

    // R4/R5 config layout
    cyc(1'b1, 2'd0, 32'h4444_1624);
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF);
    check(reg_rdata == 32'h0077_7777, "R5 cfg1 upper ignored", reg_rdata, 32'h0077_7777);
    cyc(1'b1, 2'd1, 32'h0044_4444);
    cyc(1'b0, 2'd0, 32'h0);
    check(reg_rdata == 32'h4444_1624, "R4 cfg0 readback", reg_rdata, 32'h4444_1624);
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF);
    check(reg_rdata == 32'h7777_7777, "R4 nibble bit3 zero", reg_rdata, 32'h7777_7777);
    cyc(1'b1, 2'd0, 32'h4444_1624);
    cyc(1'b1, 2'd3, 32'hFFFF_FFFF);
    check(reg_rdata == 32'h0, "R7 clear all", reg_rdata, 32'h0);
    cyc(1'b1, 2'd2, 32'hFFFF_FFFF);
    check(reg_rdata == 32'h0FFF_FFFF, "R6 mask top bits", reg_rdata, 32'h0FFF_FFFF);
    cyc(1'b1, 2'd2, 32'h0);
    check(reg_rdata == 32'h0, "R6 unmask all", reg_rdata, 32'h0);
    idle(1);
    expect_model("settle");

    // R2 latency on rising line 0
    cur_in[0] = 1'b1;
    idle(2);
    check(reg_rdata[0] == 1'b0, "R2 not yet pending", 32'(reg_rdata[0]), 32'h0);
    idle(1);
    check(reg_rdata[0] == 1'b1, "R2 pending on third edge", 32'(reg_rdata[0]), 32'h1);
    check(grp_irq == 4'b0001, "R10 group A", 32'(grp_irq), 32'h1);

    // R7 write zero keeps, write one clears
    cyc(1'b1, 2'd3, 32'hFFFF_FFFE);
    check(reg_rdata[0] == 1'b1, "R7 write0 no effect", 32'(reg_rdata[0]), 32'h1);
    pulse_clear(0);
    check(reg_rdata[0] == 1'b0, "R7 write1 clears", 32'(reg_rdata[0]), 32'h0);
    check(grp_irq == 4'b0000, "R10 group A idle", 32'(grp_irq), 32'h0);

    // R4 pair sharing: line 1 uses line 0's rising field
    cur_in[1] = 1'b1;
    idle(3);
    check(reg_rdata[1] == 1'b1, "R4 shared field line1", 32'(reg_rdata[1]), 32'h1);
    pulse_clear(1);

    // R3 falling on line 2
    cur_in[2] = 1'b1;
    idle(4);
    check(reg_rdata[2] == 1'b0, "R3 falling ignores rise", 32'(reg_rdata[2]), 32'h0);
    cur_in[2] = 1'b0;
    idle(3);
    check(reg_rdata[2] == 1'b1, "R3 falling detected", 32'(reg_rdata[2]), 32'h1);
    pulse_clear(2);

    // R3 both edges on line 4
    cur_in[4] = 1'b1;
    idle(3);
    check(reg_rdata[4] == 1'b1, "R3 both rise", 32'(reg_rdata[4]), 32'h1);
    pulse_clear(4);
    cur_in[4] = 1'b0;
    idle(3);
    check(reg_rdata[4] == 1'b1, "R3 both fall", 32'(reg_rdata[4]), 32'h1);
    pulse_clear(4);

    // R8 high level re-sets until removed
    cur_in[6] = 1'b1;
    idle(3);
    pulse_clear(6);
    check(reg_rdata[6] == 1'b1, "R8 level holds", 32'(reg_rdata[6]), 32'h1);
    cur_in[6] = 1'b0;
    idle(3);
    pulse_clear(6);
    check(reg_rdata[6] == 1'b0, "R8 level removed clears", 32'(reg_rdata[6]), 32'h0);

    // R8 edge meets clear in the same cycle
    cur_in[8] = 1'b1;
    idle(2);
    pulse_clear(8);
    check(reg_rdata[8] == 1'b1, "R8 set wins", 32'(reg_rdata[8]), 32'h1);
    pulse_clear(8);
    check(reg_rdata[8] == 1'b0, "R8 later clear", 32'(reg_rdata[8]), 32'h0);

    // R9 masked line still pends
    cyc(1'b1, 2'd2, 32'h1 << 9);
    cur_in[9] = 1'b1;
    idle(3);
    check(reg_rdata[9] == 1'b1, "R9 masked pends", 32'(reg_rdata[9]), 32'h1);
    check(grp_irq[1] == 1'b0, "R9 masked hidden", 32'(grp_irq), 32'h0);
    cyc(1'b1, 2'd2, 32'h0);
    check(grp_irq[1] == 1'b1, "R9 unmask reveals", 32'(grp_irq), 32'h2);
    pulse_clear(9);
    expect_model("after mask");

    // R10 group boundaries
    cur_in = '0;
    cyc(1'b1, 2'd0, 32'h4444_4444);
    idle(4);
    cyc(1'b1, 2'd3, 32'h0FFF_FFFF);
    check(grp_irq == 4'h0, "R10 all clear", 32'(grp_irq), 32'h0);
    begin
      int lines [6] = '{3, 11, 12, 19, 20, 27};
      int grps  [6] = '{0, 1, 2, 2, 3, 3};
      for (int k = 0; k < 6; k++) begin
        cur_in[lines[k]] = 1'b1;
        idle(3);
        check(grp_irq == (4'b1 << grps[k]), $sformatf("R10 line %0d", lines[k]),
              32'(grp_irq), 32'(4'b1 << grps[k]));
        pulse_clear(lines[k]);
        check(grp_irq == 4'h0, "R10 group drops", 32'(grp_irq), 32'h0);
        cur_in[lines[k]] = 1'b0;
        idle(3);
      end
    end

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      cur_in = cur_in ^ (28'($urandom) & 28'($urandom) & 28'($urandom));
      r = int'($urandom % 16);
      if (r == 0)      cyc(1'b1, 2'($urandom % 2), $urandom);
      else if (r == 1) cyc(1'b1, 2'd2, $urandom);
      else if (r < 6)  cyc(1'b1, 2'd3, $urandom);
      else             cyc(1'b0, 2'($urandom), 32'h0);
      expect_model("random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule